// File: doc/BRIEF.md
# Double-Buffered BCD Real-Time Clock Registers

This block holds the time of day and the calendar for a real-time clock. It is organised as two layers. A set of live BCD counters (seconds, minutes, hours, day of week, date, month, year and century) advances once for every pulse on a one-second tick input. Calendar rollover follows the length of each month, and February has 29 days when the year is divisible by four. Above the counters sits a user layer that a simple synchronous register bus reads and writes.

While software is not holding the user layer, it copies the counters on every clock cycle. Two control bits in the century register stop that copy without stopping the counters. The read-hold bit keeps a multi-byte read consistent. The write-hold bit lets software load a new time. Clearing the write-hold bit copies the loaded values into the counters in a single cycle. Register bits that have no meaning are forced to zero when written and read back as zero.

Top module: `bcd_clock_regfile`

## Requirements
- R1: After reset the registers read: address 0 = 0x20 (both control bits clear, century 20), seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00.
- R2: Each tick adds one to the BCD seconds. 59 seconds rolls to 00 and carries into minutes. 59 minutes rolls to 00 and carries into hours. Hour 23 rolls to 00 and carries into both the day (07 rolls to 01) and the date.
- R3: The date rolls to 01 after 30 in April, June, September and November, after 31 in the other months, and in February after 29 when the year is divisible by 4 and after 28 otherwise. Month 12 rolls to 01 and carries into the year. Year 99 rolls to 00 and adds one to the century (bits 5:0 of address 0).
- R4: While both control bits are clear, every user register is refreshed from the live counters on each cycle. A tick can be read on the bus two cycles after it is applied.
- R5: Bit 6 of address 0 is the read-hold bit. While it is set the user registers keep their values and the counters keep counting. After it is cleared, reads show the advanced time.
- R6: Bit 7 of address 0 is the write-hold bit. While it is set the user registers change only through bus writes, and reads return the written values.
- R7: A write to address 0 with bit 7 = 0 while the write-hold bit is set loads the live counters from the user registers. The century is taken from bits 5:0 of that same write. The write-hold bit clears.
- R8: A tick that arrives in the commit cycle is dropped. The committed time advances by exactly one second at the next tick.
- R9: Writable bits per address: 0 = 0xFF (7 = write-hold, 6 = read-hold, 5:0 = century), 1 = 0x7F, 2 = 0x7F, 3 = 0x3F, 4 = 0x07, 5 = 0x3F, 6 = 0x1F, 7 = 0xFF. All other bits are stored and read as 0.
- R10: Read data is registered. It takes the addressed value at the clock edge where the read strobe is high, and it holds that value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse for each elapsed second |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data |

## Verification
The bench builds the block with its defaults: ADDR_W = 3, DATA_W = 8, RESET_CENT = 0x20 and READ_REG = 1. With a three-bit address every address decodes to a register, so no address is left unused. The registered read path brings the hold behaviour of R10 within reach. The bench uses the write-hold path to load times just before the rollover points: ends of months, February in leap and common years, the end of the year, and a commit that lands in the same cycle as a tick. This reaches every carry path without counting through whole days.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

   localparam int NUM_FIELDS = 8;
   localparam int FIELD_W    = 8;

   // field index equals bus address
   typedef enum logic [2:0] {
      F_CENT = 3'd0, F_SEC = 3'd1, F_MIN = 3'd2, F_HOUR = 3'd3,
      F_WDAY = 3'd4, F_DATE = 3'd5, F_MONTH = 3'd6, F_YEAR = 3'd7
   } field_e;

   function automatic logic [7:0] field_mask(input int idx);
      logic [7:0] m;
      case (idx)
         0:       m = 8'h3F;
         1, 2:    m = 8'h7F;
         3, 5:    m = 8'h3F;
         4:       m = 8'h07;
         6:       m = 8'h1F;
         default: m = 8'hFF;
      endcase
      return m;
   endfunction

   function automatic logic [NUM_FIELDS*8-1:0] all_masks();
      logic [NUM_FIELDS*8-1:0] r;
      for (int i = 0; i < NUM_FIELDS; i++) r[8*i +: 8] = field_mask(i);
      return r;
   endfunction

   function automatic logic [7:0] field_lo(input int idx);
      return (idx == 4 || idx == 5 || idx == 6) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] field_hi(input int idx);
      logic [7:0] h;
      case (idx)
         0:       h = 8'h39;
         1, 2:    h = 8'h59;
         3:       h = 8'h23;
         4:       h = 8'h07;
         5:       h = 8'h31;
         6:       h = 8'h12;
         default: h = 8'h99;
      endcase
      return h;
   endfunction

   function automatic logic [7:0] reset_val(input int idx, input logic [7:0] cent);
      logic [7:0] v;
      if (idx == 0) v = cent & 8'h3F;
      else          v = field_lo(idx);
      return v;
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      logic [7:0] ybin;
      logic [7:0] len;
      ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
      case (mon)
         8'h02:                      len = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: len = 8'h30;
         default:                    len = 8'h31;
      endcase
      return len;
   endfunction

endpackage

// File: rtl/bcd_field_step.sv
module bcd_field_step
   import bcd_clock_pkg::*;
(
   input  logic       en,
   input  logic [7:0] cur,
   input  logic [7:0] lo,
   input  logic [7:0] hi,
   output logic [7:0] nxt,
   output logic       at_max
);
   assign at_max = (cur == hi);

   always_comb begin
      nxt = cur;
      if (en) nxt = at_max ? lo : bcd_inc(cur);
   end
endmodule

// File: rtl/bcd_time_core.sv
module bcd_time_core
   import bcd_clock_pkg::*;
#(
   parameter logic [7:0] RESET_CENT = 8'h20
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       load,
   input  logic [NUM_FIELDS*8-1:0]    load_val,
   output logic [NUM_FIELDS*8-1:0]    live
);
   logic [7:0]            cur    [NUM_FIELDS];
   logic [7:0]            nxt    [NUM_FIELDS];
   logic [7:0]            hi_sel [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] at_max;
   logic [NUM_FIELDS-1:0] step;
   logic s_sec, s_min, s_hour, s_day, s_mon, s_year, s_cent;

   // carry chain: a commit (load) wins over a coincident tick
   always_comb begin
      s_sec  = tick & ~load;
      s_min  = s_sec  & at_max[F_SEC];
      s_hour = s_min  & at_max[F_MIN];
      s_day  = s_hour & at_max[F_HOUR];
      s_mon  = s_day  & at_max[F_DATE];
      s_year = s_mon  & at_max[F_MONTH];
      s_cent = s_year & at_max[F_YEAR];
      step   = {s_year, s_mon, s_day, s_day, s_hour, s_min, s_sec, s_cent};
   end

   always_comb begin
      for (int i = 0; i < NUM_FIELDS; i++) hi_sel[i] = field_hi(i);
      hi_sel[F_DATE] = month_len(cur[F_MONTH], cur[F_YEAR]);
   end

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      bcd_field_step u_step (
         .en     (step[g]),
         .cur    (cur[g]),
         .lo     (field_lo(g)),
         .hi     (hi_sel[g]),
         .nxt    (nxt[g]),
         .at_max (at_max[g])
      );
      assign live[8*g +: 8] = cur[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) cur[i] <= reset_val(i, RESET_CENT);
      end else begin
         for (int i = 0; i < NUM_FIELDS; i++)
            cur[i] <= load ? load_val[8*i +: 8] : nxt[i];
      end
   end
endmodule

// File: rtl/bcd_clock_regfile.sv
module bcd_clock_regfile
   import bcd_clock_pkg::*;
#(
   parameter int         ADDR_W     = 3,
   parameter int         DATA_W     = 8,
   parameter logic [7:0] RESET_CENT = 8'h20,
   parameter bit         READ_REG   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int SEL_W = $clog2(NUM_FIELDS);
   localparam int FLAT  = NUM_FIELDS * 8;

   if (DATA_W != FIELD_W) begin : g_bad_data_w
      $error("bcd_clock_regfile: DATA_W must be 8");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr_w
      $error("bcd_clock_regfile: ADDR_W too small for the register map");
   end
   if (RESET_CENT[7:4] > 4'd3 || RESET_CENT[3:0] > 4'd9) begin : g_bad_cent
      $error("bcd_clock_regfile: RESET_CENT must be BCD 00..39");
   end

   logic [7:0]       usr [NUM_FIELDS];
   logic [FLAT-1:0]  usr_flat;
   logic [FLAT-1:0]  live_flat;
   logic [FLAT-1:0]  load_val;
   logic             ctl_w_q, ctl_r_q;
   logic             addr_ok, wr_en, commit, freeze;
   logic [SEL_W-1:0] sel;
   logic [7:0]       rd_val;

   assign sel = bus_addr[SEL_W-1:0];

   if (ADDR_W > SEL_W) begin : g_addr_hi
      assign addr_ok = ~|bus_addr[ADDR_W-1:SEL_W];
   end else begin : g_addr_full
      assign addr_ok = 1'b1;
   end

   assign wr_en  = bus_we & addr_ok;
   assign freeze = ctl_w_q | ctl_r_q;
   assign commit = wr_en & (sel == '0) & ctl_w_q & ~bus_wdata[7];

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_flat
      assign usr_flat[8*g +: 8] = usr[g];
   end

   assign load_val = {usr_flat[FLAT-1:8], 2'b00, bus_wdata[5:0]};

   bcd_time_core #(.RESET_CENT(RESET_CENT)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sec_tick),
      .load     (commit),
      .load_val (load_val),
      .live     (live_flat)
   );

   // user layer: bus writes win, otherwise refresh unless held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) usr[i] <= reset_val(i, RESET_CENT);
         ctl_w_q <= 1'b0;
         ctl_r_q <= 1'b0;
      end else begin
         for (int i = 0; i < NUM_FIELDS; i++) begin
            if (wr_en && sel == SEL_W'(i)) usr[i] <= bus_wdata & field_mask(i);
            else if (!freeze)              usr[i] <= live_flat[8*i +: 8];
         end
         if (wr_en && sel == '0) begin
            ctl_w_q <= bus_wdata[7];
            ctl_r_q <= bus_wdata[6];
         end
      end
   end

   always_comb begin
      rd_val = usr[sel];
      if (sel == '0) rd_val = {ctl_w_q, ctl_r_q, usr[0][5:0]};
      if (!addr_ok)  rd_val = '0;
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_re) bus_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end
endmodule

// File: rtl/bcd_clock_checker.sv
module bcd_clock_checker
   import bcd_clock_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter bit READ_REG = 1'b1
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sec_tick,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [7:0]              bus_wdata,
   input logic                    bus_we,
   input logic                    bus_re,
   input logic [7:0]              bus_rdata,
   input logic [NUM_FIELDS*8-1:0] live,
   input logic [NUM_FIELDS*8-1:0] usr_flat,
   input logic                    ctl_w,
   input logic                    ctl_r
);
   localparam logic [NUM_FIELDS*8-1:0] MASK_ALL = all_masks();

   logic wr0, commit;
   assign wr0    = bus_we && (bus_addr == '0);
   assign commit = wr0 && ctl_w && !bus_wdata[7];

   p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live[15:12] <= 4'd5 && live[11:8] <= 4'd9);

   p_hour_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live[31:24] <= 8'h23);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick && !commit |=> $stable(live));

   p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_w && !ctl_r && !bus_we |=> usr_flat == $past(live));

   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w || ctl_r) && !bus_we |=> $stable(usr_flat));

   p_ctl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr0 |=> ctl_w == $past(bus_wdata[7]) && ctl_r == $past(bus_wdata[6]));

   p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !ctl_w && live[63:8] == $past(usr_flat[63:8])
                 && live[5:0] == $past(bus_wdata[5:0]));

   p_commit_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit && sec_tick |=> live[15:8] == $past(usr_flat[15:8]));

   p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_flat & ~MASK_ALL) == '0);

   if (READ_REG) begin : g_rd_chk
      p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_re |=> $stable(bus_rdata));
   end
endmodule

bind bcd_clock_regfile bcd_clock_checker #(
   .ADDR_W   (ADDR_W),
   .READ_REG (READ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .live      (live_flat),
   .usr_flat  (usr_flat),
   .ctl_w     (ctl_w_q),
   .ctl_r     (ctl_r_q)
);

// File: tb/sim_bcd_clock_regfile.sv
module sim_bcd_clock_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic       bus_re = 1'b0;
   logic [7:0] bus_rdata;

   always #2.5 clk = ~clk;

   bcd_clock_regfile u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
   );

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t sb[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   function automatic void check(input logic [7:0] got, input logic [7:0] exp, input string tag);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endfunction

   // monitor: compares registered read data one edge after each strobe
   initial forever begin
      @(posedge clk);
      if (bus_re) begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(bus_rdata, it.exp, it.tag);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit with_tick = 1'b0);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1; sec_tick = with_tick;
      @(negedge clk);
      bus_we = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      sb.push_back('{exp, tag});
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      sec_tick = 1'b1;
      repeat (n) @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_time(input logic [7:0] cent, input logic [7:0] yr, input logic [7:0] mon,
                           input logic [7:0] dt, input logic [7:0] wd, input logic [7:0] hr,
                           input logic [7:0] mi, input logic [7:0] se);
      wr(3'd0, {2'b10, cent[5:0]});
      wr(3'd1, se); wr(3'd2, mi); wr(3'd3, hr); wr(3'd4, wd);
      wr(3'd5, dt); wr(3'd6, mon); wr(3'd7, yr);
      wr(3'd0, {2'b00, cent[5:0]});
      idle(2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd(3'd0, 8'h20, "R1 control/century");
      rd(3'd1, 8'h00, "R1 seconds");
      rd(3'd2, 8'h00, "R1 minutes");
      rd(3'd3, 8'h00, "R1 hours");
      rd(3'd4, 8'h01, "R1 day");
      rd(3'd5, 8'h01, "R1 date");
      rd(3'd6, 8'h01, "R1 month");
      rd(3'd7, 8'h00, "R1 year");

      // R2 / R4 counting and mirroring
      ticks(1); idle(1);
      rd(3'd1, 8'h01, "R4 tick visible");
      ticks(9); idle(1);
      rd(3'd1, 8'h10, "R2 BCD digit carry");

      // R5 read hold
      wr(3'd0, 8'h60);
      ticks(5); idle(1);
      rd(3'd1, 8'h10, "R5 held seconds");
      rd(3'd0, 8'h60, "R5 control readback");
      wr(3'd0, 8'h20); idle(2);
      rd(3'd1, 8'h15, "R5 counters kept running");

      // R6 / R9 write hold and masking
      wr(3'd0, 8'hA0);
      wr(3'd1, 8'hD9); wr(3'd2, 8'h59); wr(3'd3, 8'hE3); wr(3'd4, 8'hFB);
      wr(3'd5, 8'h28); wr(3'd6, 8'hE2); wr(3'd7, 8'h23);
      rd(3'd4, 8'h03, "R9 day mask");
      rd(3'd3, 8'h23, "R9 hour mask");
      rd(3'd6, 8'h02, "R9 month mask");
      rd(3'd1, 8'h59, "R9 seconds mask");
      ticks(3); idle(1);
      rd(3'd1, 8'h59, "R6 held during load");
      rd(3'd0, 8'hA0, "R6 control readback");

      // R7 commit
      wr(3'd0, 8'h20); idle(2);
      rd(3'd1, 8'h59, "R7 seconds committed");
      rd(3'd2, 8'h59, "R7 minutes committed");
      rd(3'd3, 8'h23, "R7 hours committed");
      rd(3'd5, 8'h28, "R7 date committed");
      rd(3'd6, 8'h02, "R7 month committed");
      rd(3'd7, 8'h23, "R7 year committed");
      rd(3'd0, 8'h20, "R7 write bit cleared");
      ticks(1); idle(1);
      rd(3'd1, 8'h00, "R2 seconds wrap");
      rd(3'd2, 8'h00, "R2 minutes wrap");
      rd(3'd3, 8'h00, "R2 hours wrap");
      rd(3'd4, 8'h04, "R2 day advance");
      rd(3'd5, 8'h01, "R3 Feb common year end");
      rd(3'd6, 8'h03, "R3 month advance");

      // R3 leap February
      set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59);
      ticks(1); idle(1);
      rd(3'd5, 8'h29, "R3 leap Feb 29");
      rd(3'd6, 8'h02, "R3 leap month kept");
      rd(3'd4, 8'h06, "R2 day 5 to 6");

      // R3 end of year / century, R2 day 7 to 1
      set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      ticks(1); idle(1);
      rd(3'd7, 8'h00, "R3 year wrap");
      rd(3'd6, 8'h01, "R3 month wrap");
      rd(3'd5, 8'h01, "R3 date wrap Dec");
      rd(3'd4, 8'h01, "R2 day 7 to 1");
      rd(3'd0, 8'h21, "R3 century advance");

      // R3 30-day month
      set_time(8'h21, 8'h01, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      ticks(1); idle(1);
      rd(3'd6, 8'h05, "R3 April end month");
      rd(3'd5, 8'h01, "R3 April end date");

      // R2 minute to hour carry without date change
      set_time(8'h21, 8'h01, 8'h05, 8'h01, 8'h03, 8'h10, 8'h59, 8'h59);
      ticks(1); idle(1);
      rd(3'd3, 8'h11, "R2 hour carry");
      rd(3'd2, 8'h00, "R2 minute wrap");
      rd(3'd5, 8'h01, "R2 date unchanged mid-day");

      // R8 tick coinciding with commit
      wr(3'd0, 8'h95);
      wr(3'd1, 8'h30);
      wr(3'd0, 8'h15, 1'b1);
      idle(2);
      rd(3'd1, 8'h30, "R8 tick dropped at commit");
      rd(3'd0, 8'h15, "R7 century from commit write");
      ticks(1); idle(1);
      rd(3'd1, 8'h31, "R8 next tick advances one");

      // R10 read data holds without strobe
      wait (sb.size() == 0);
      idle(1);
      ticks(4); idle(2);
      check(bus_rdata, 8'h31, "R10 read data held");

      wait (sb.size() == 0);
      idle(2);
      finish_run();
   end
endmodule